// File: doc/BRIEF.md
# Four-Group Lookahead Carry Unit

This block sits above a row of four small adder groups. Each group reports whether it would pass an incoming carry straight through (propagate) and whether it creates a carry on its own (generate). From these four pairs and a single carry-in, the unit works out the carry into every upper group and the carry leaving the top group. All of these carries are computed at the same time, so no carry has to travel through the groups below it.

The unit also sums its four groups into one block-level propagate and one block-level generate. These two outputs let the unit act as a single group for a parent unit of the same design. A tree of these units then covers any width that is a power of four. A leaf takes its carry-in from its parent's carry outputs. The design has no clock and no state, and no valid/ready handshake applies, because nothing is held or queued. Every output follows its inputs through two levels of logic.

Top module: `lookahead_carry4`

## Requirements
- R1: `c_grp[1]` is `g_grp[0] | (p_grp[0] & c_in)`.
- R2: `c_grp[2]` is `g_grp[1] | (g_grp[0] & p_grp[1]) | (c_in & p_grp[0] & p_grp[1])`. It is formed from the inputs directly and does not wait on `c_grp[1]`.
- R3: `c_grp[3]` is `g_grp[2] | g_grp[1]&p_grp[2] | g_grp[0]&p_grp[1]&p_grp[2] | c_in&p_grp[0]&p_grp[1]&p_grp[2]`.
- R4: `c_out` is the carry above group 3. It is the OR of `g_grp[3]` and of each lower generate or `c_in`, each ANDed with every propagate above its own position.
- R5: `p_blk` is 1 exactly when all four bits of `p_grp` are 1.
- R6: `g_blk` is `g_grp[3] | g_grp[2]&p_grp[3] | g_grp[1]&p_grp[2]&p_grp[3] | g_grp[0]&p_grp[1]&p_grp[2]&p_grp[3]`. It does not depend on `c_in`.
- R7: `c_out` always equals `g_blk | (c_in & p_blk)`.
- R8: All outputs are combinational. A change on any input shows at the outputs with no clock edge in between.
- R9: Five instances nest into a 16-group tree. In the tree, each of four leaves takes its `c_in` from the root: leaf 0 from the root's `c_in`, and leaves 1 to 3 from root `c_grp[1..3]`. The root takes each leaf's `p_blk` and `g_blk` as its own group pair. Every carry in the tree then matches a carry rippled one group at a time across all 16 groups, and the root's `c_out` is the carry above group 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| p_grp | input | 4 | Propagate flag from each lower group, bit i for group i |
| g_grp | input | 4 | Generate flag from each lower group, bit i for group i |
| c_in | input | 1 | Carry into group 0 |
| c_grp | output | 3 | Carries into groups 1 to 3, indexed [3:1] |
| c_out | output | 1 | Carry out above group 3 |
| p_blk | output | 1 | Block propagate, for a parent unit |
| g_blk | output | 1 | Block generate, for a parent unit |

## Verification
The hardest case to reach is a carry that starts at the tree's carry-in and crosses every propagate in a nested tree to reach the root's carry-out. This needs all 16 propagates high and every generate low, and random inputs produce that about once in 4^16 draws. The stimulus forces this case, and its near misses, with directed patterns: a full propagate chain with each carry-in value, and a chain broken or seeded at single positions. Random 16-group draws then cover mixed patterns. The single unit is covered exhaustively over all 512 input combinations.

// File: rtl/lcu_pkg.sv
package lcu_pkg;

  // Widest row of groups any instance may be configured for.
  localparam int MAX_GROUPS = 16;

  // AND of the bits of v whose index lies in [lo, hi]; an empty span yields 1.
  function automatic logic span_and(input logic [MAX_GROUPS-1:0] v,
                                    input int lo, input int hi);
    logic acc;
    acc = 1'b1;
    for (int i = 0; i < MAX_GROUPS; i++) begin
      if (i >= lo && i <= hi) acc = acc & v[i];
    end
    return acc;
  endfunction

endpackage

// File: rtl/lcu_carry_sop.sv
// Flat sum-of-products for every carry position 1..GROUPS.
module lcu_carry_sop #(
  parameter int GROUPS = 4
) (
  input  logic [GROUPS-1:0] p_grp,
  input  logic [GROUPS-1:0] g_grp,
  input  logic              c_in,
  output logic [GROUPS:1]   carry
);
  import lcu_pkg::*;

  logic [MAX_GROUPS-1:0] p_ext;
  assign p_ext = MAX_GROUPS'(p_grp);

  for (genvar k = 1; k <= GROUPS; k++) begin : g_pos
    // terms[0]: carry-in passed through groups 0..k-1
    // terms[j+1]: generate at j passed through groups j+1..k-1
    logic [k:0] terms;
    assign terms[0] = c_in & span_and(p_ext, 0, k - 1);
    for (genvar j = 0; j < k; j++) begin : g_term
      assign terms[j+1] = g_grp[j] & span_and(p_ext, j + 1, k - 1);
    end
    assign carry[k] = |terms;
  end

endmodule

// File: rtl/lcu_block_pg.sv
// Block-level propagate and generate, independent of the carry-in.
module lcu_block_pg #(
  parameter int GROUPS = 4
) (
  input  logic [GROUPS-1:0] p_grp,
  input  logic [GROUPS-1:0] g_grp,
  output logic              p_blk,
  output logic              g_blk
);
  import lcu_pkg::*;

  logic [MAX_GROUPS-1:0] p_ext;
  logic [GROUPS-1:0]     g_terms;

  assign p_ext = MAX_GROUPS'(p_grp);
  assign p_blk = span_and(p_ext, 0, GROUPS - 1);

  for (genvar j = 0; j < GROUPS; j++) begin : g_term
    assign g_terms[j] = g_grp[j] & span_and(p_ext, j + 1, GROUPS - 1);
  end
  assign g_blk = |g_terms;

endmodule

// File: rtl/lookahead_carry4.sv
module lookahead_carry4 #(
  parameter int GROUPS = 4
) (
  input  logic [GROUPS-1:0] p_grp,
  input  logic [GROUPS-1:0] g_grp,
  input  logic              c_in,
  output logic [GROUPS-1:1] c_grp,
  output logic              c_out,
  output logic              p_blk,
  output logic              g_blk
);

  logic [GROUPS:1] carry;

  lcu_carry_sop #(.GROUPS(GROUPS)) u_carry (
    .p_grp (p_grp),
    .g_grp (g_grp),
    .c_in  (c_in),
    .carry (carry)
  );

  lcu_block_pg #(.GROUPS(GROUPS)) u_blk (
    .p_grp (p_grp),
    .g_grp (g_grp),
    .p_blk (p_blk),
    .g_blk (g_blk)
  );

  assign c_grp = carry[GROUPS-1:1];
  assign c_out = carry[GROUPS];

endmodule

// File: rtl/lcu_checker.sv
module lcu_checker #(
  parameter int GROUPS = 4
) (
  input logic [GROUPS-1:0] p_grp,
  input logic [GROUPS-1:0] g_grp,
  input logic              c_in,
  input logic [GROUPS-1:1] c_grp,
  input logic              c_out,
  input logic              p_blk,
  input logic              g_blk
);

  logic [GROUPS:0] chain;
  assign chain = {c_out, c_grp, c_in};

  always_comb begin
    // R1: lowest carry follows group 0 and the carry-in
    assert_c1_R1: assert (chain[1] == (g_grp[0] | (p_grp[0] & c_in)))
      else $error("R1 carry 1 mismatch");
    // R2, R3, R4: flat outputs agree with a one-step recurrence between neighbours
    for (int i = 1; i < GROUPS; i++) begin
      assert_chain_R2: assert (chain[i+1] == (g_grp[i] | (p_grp[i] & chain[i])))
        else $error("R2/R3/R4 carry %0d breaks recurrence", i + 1);
    end
    // R7: carry-out agrees with the block pair from the other sub-unit
    assert_cout_split_R7: assert (c_out == (g_blk | (c_in & p_blk)))
      else $error("R7 c_out vs block pair");
    // R6: a block generate forces a carry-out
    assert_gen_forces_R6: assert (!g_blk || c_out)
      else $error("R6 g_blk without c_out");
    // R5: a full propagate with no generate passes the carry-in straight up
    assert_pass_R5: assert (!(p_blk && !g_blk) || (c_out == c_in))
      else $error("R5 pass-through broken");
  end

endmodule

bind lookahead_carry4 lcu_checker #(.GROUPS(GROUPS)) u_chk (
  .p_grp (p_grp),
  .g_grp (g_grp),
  .c_in  (c_in),
  .c_grp (c_grp),
  .c_out (c_out),
  .p_blk (p_blk),
  .g_blk (g_blk)
);

// File: tb/lookahead_carry4_tb.sv
module lookahead_carry4_tb;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  // single unit under test
  logic [3:0] p_in, g_in;
  logic       cin_in;
  logic [3:1] c_o;
  logic       cout_o, pb_o, gb_o;

  lookahead_carry4 u_dut (
    .p_grp (p_in), .g_grp (g_in), .c_in (cin_in),
    .c_grp (c_o), .c_out (cout_o), .p_blk (pb_o), .g_blk (gb_o)
  );

  // two-level tree over 16 groups
  logic [15:0] tp, tg;
  logic        tcin;
  logic [3:0]  leaf_cin, leaf_pb, leaf_gb, leaf_co;
  logic [3:1]  leaf_c [4];
  logic [3:1]  root_c;
  logic        root_co, root_pb, root_gb;

  lookahead_carry4 u_root (
    .p_grp (leaf_pb), .g_grp (leaf_gb), .c_in (tcin),
    .c_grp (root_c), .c_out (root_co), .p_blk (root_pb), .g_blk (root_gb)
  );
  assign leaf_cin = {root_c, tcin};

  for (genvar L = 0; L < 4; L++) begin : g_leaf
    lookahead_carry4 u_leaf (
      .p_grp (tp[4*L +: 4]), .g_grp (tg[4*L +: 4]), .c_in (leaf_cin[L]),
      .c_grp (leaf_c[L]), .c_out (leaf_co[L]), .p_blk (leaf_pb[L]), .g_blk (leaf_gb[L])
    );
  end

  // reference: ripple one group at a time
  function automatic logic [4:0] ref4(input logic [3:0] p, input logic [3:0] g, input logic ci);
    logic [4:0] c;
    c[0] = ci;
    for (int i = 0; i < 4; i++) c[i+1] = g[i] | (p[i] & c[i]);
    return c;
  endfunction

  function automatic logic [16:0] ref16(input logic [15:0] p, input logic [15:0] g, input logic ci);
    logic [16:0] c;
    c[0] = ci;
    for (int i = 0; i < 16; i++) c[i+1] = g[i] | (p[i] & c[i]);
    return c;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  task automatic check_unit(input logic [3:0] p, input logic [3:0] g, input logic ci);
    logic [4:0] r;
    logic [4:0] rg;
    @(negedge clk);
    p_in = p; g_in = g; cin_in = ci;
    #1;
    r  = ref4(p, g, ci);
    rg = ref4(p, g, 1'b0);
    check("R1", 32'(c_o[1]), 32'(r[1]));
    check("R2", 32'(c_o[2]), 32'(r[2]));
    check("R3", 32'(c_o[3]), 32'(r[3]));
    check("R4", 32'(cout_o), 32'(r[4]));
    check("R5", 32'(pb_o), 32'(&p));
    check("R6", 32'(gb_o), 32'(rg[4]));
    check("R7", 32'(cout_o), 32'(gb_o | (ci & pb_o)));
  endtask

  task automatic check_tree(input logic [15:0] p, input logic [15:0] g, input logic ci);
    logic [16:0] r;
    @(negedge clk);
    tp = p; tg = g; tcin = ci;
    #1;
    r = ref16(p, g, ci);
    for (int L = 0; L < 4; L++) begin
      check("R9 leaf c1", 32'(leaf_c[L][1]), 32'(r[4*L+1]));
      check("R9 leaf c2", 32'(leaf_c[L][2]), 32'(r[4*L+2]));
      check("R9 leaf c3", 32'(leaf_c[L][3]), 32'(r[4*L+3]));
      check("R9 leaf cout", 32'(leaf_co[L]), 32'(r[4*L+4]));
    end
    check("R9 root cout", 32'(root_co), 32'(r[16]));
    check("R9 root pblk", 32'(root_pb), 32'(&p));
  endtask

  initial begin
    #(8 * 200000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [8:0] v;
    int unsigned seed;
    p_in = '0; g_in = '0; cin_in = 1'b0;
    tp = '0; tg = '0; tcin = 1'b0;
    seed = $urandom(32'd20240611);

    // idle inputs: every output low
    #1;
    check("R4 idle", 32'({c_o, cout_o, gb_o}), 32'd0);
    check("R5 idle", 32'(pb_o), 32'd0);

    // exhaustive single unit
    for (int i = 0; i < 512; i++) begin
      v = 9'(i);
      check_unit(v[3:0], v[7:4], v[8]);
    end

    // R8: inputs changed mid-cycle, outputs follow with no clock edge
    @(posedge clk);
    #1;
    p_in = 4'hF; g_in = 4'h0; cin_in = 1'b1;
    #1;
    check("R8 follow", 32'({c_o, cout_o}), 32'hF);
    cin_in = 1'b0;
    #1;
    check("R8 follow", 32'({c_o, cout_o}), 32'h0);

    // directed tree corners: full propagate chain, broken and seeded chains
    check_tree(16'hFFFF, 16'h0000, 1'b1);
    check_tree(16'hFFFF, 16'h0000, 1'b0);
    for (int b = 0; b < 16; b++) begin
      check_tree(16'hFFFF & ~(16'h1 << b), 16'h0000, 1'b1);
      check_tree(16'hFFFF, 16'h1 << b, 1'b0);
    end

    // random tree patterns
    for (int n = 0; n < 2000; n++) begin
      check_tree(16'($urandom), 16'($urandom) & 16'($urandom), 1'($urandom));
    end

    finish_run();
  end

endmodule